// File: doc/BRIEF.md
# Masked Vector Element Execution Unit

This unit runs element-wise integer vector instructions over a small bank of vector registers. One instruction is accepted at a time. A vector instruction then steps through its elements one per clock, and each element goes through a pipeline of fixed depth. Two control registers shape every vector instruction. The length register limits how many leading elements are processed. The mask register selects which of those elements are actually written.

Four arithmetic forms are available: add and multiply, each with either two vector sources or a broadcast scalar and a vector. An equality compare fills the mask register. Two single-cycle instructions load the length register or the mask register from the scalar operand. A host-side write port fills the vector registers, and a combinational read port returns any element. The mask and length registers are visible as outputs. `busy` is high while a vector instruction is in flight, and `done` pulses once when it ends.

Top module: `vec_mask_exec`

## Requirements
- R1: After reset, `busy` and `done` are low, the length register holds MAX_LEN (64) and every mask bit is 1.
- R2: Opcode 0 writes dst[i] = A[i] + B[i]. Opcode 1 writes dst[i] = scalar + B[i], with the low ELEM_W bits of the scalar broadcast to every element. Sums wrap modulo 2^ELEM_W.
- R3: Opcode 2 writes dst[i] = A[i] * B[i]. Opcode 3 writes dst[i] = scalar * B[i]. Each keeps the low ELEM_W bits of the product.
- R4: Opcode 4 sets mask bit i to 1 when A[i] equals B[i] and to 0 otherwise, for every i below the length. It ignores the current mask and changes no vector register.
- R5: An arithmetic instruction writes element i only when mask bit i is 1. Elements with mask bit 0 keep their old value.
- R6: Elements at an index equal to or above the length register are never written, and neither are their mask bits.
- R7: Opcode 5 loads the length register from the scalar, clamped to MAX_LEN. Opcode 6 loads the mask register from the low MAX_LEN scalar bits. Both take effect on the next clock and do not raise `busy`. Opcode 7 is accepted and has no effect.
- R8: For a vector instruction accepted on clock edge A with length L, `done` is high for exactly one cycle, the cycle after edge A+L+PIPE_D, and `busy` falls on that same edge. This timing does not depend on the mask contents.
- R9: While `busy` is high, `issueAccept` is low and an offered instruction is discarded: it changes neither the length, the mask nor any register.
- R10: A vector instruction with length 0 writes nothing and still completes PIPE_D+1 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction offered |
| issueOp | input | 3 | Opcode, 0 to 7 |
| issueDst | input | $clog2(NUM_REGS) | Destination register |
| issueSrcA | input | $clog2(NUM_REGS) | First source register |
| issueSrcB | input | $clog2(NUM_REGS) | Second source register |
| issueScalar | input | max(MAX_LEN, ELEM_W) | Scalar operand, length value or mask value |
| issueAccept | output | 1 | Instruction taken this cycle |
| busy | output | 1 | Vector instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| hostWrEn | input | 1 | Host element write strobe |
| hostWrReg | input | $clog2(NUM_REGS) | Host write register |
| hostWrIdx | input | $clog2(MAX_LEN) | Host write element index |
| hostWrData | input | ELEM_W | Host write data |
| rdReg | input | $clog2(NUM_REGS) | Read register select |
| rdIdx | input | $clog2(MAX_LEN) | Read element index |
| rdData | output | ELEM_W | Selected element, combinational |
| vlOut | output | $clog2(MAX_LEN+1) | Current length register |
| maskOut | output | MAX_LEN | Current mask register |

## Verification
The assertions assume that the host write port stays idle while `busy` is high. They also assume that nothing else touches the length register during an instruction, apart from the refusal path that R9 covers. The bench keeps to this: it loads the registers only before issuing and waits for `done` before it touches any port other than the issue inputs. The only instructions it offers during a run are deliberately refused ones, and the bench checks that they leave no trace.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  typedef enum logic [2:0] {
    OP_ADDVV   = 3'd0,
    OP_ADDSV   = 3'd1,
    OP_MULVV   = 3'd2,
    OP_MULSV   = 3'd3,
    OP_CMPEQ   = 3'd4,
    OP_SETVL   = 3'd5,
    OP_SETMASK = 3'd6,
    OP_NOP     = 3'd7
  } vop_e;

  typedef struct packed {
    logic start;
    logic loadVl;
    logic loadMask;
    logic elemIssue;
  } vctl_t;
endpackage

// File: rtl/vmu_ctrl.sv
module vmu_ctrl
  import vmu_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int PIPE_D  = 3,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  vop_e             issueOp,
  input  logic [LEN_W-1:0] vlCur,
  output logic             issueAccept,
  output logic             busy,
  output logic             done,
  output vctl_t            ctl,
  output logic [IDX_W-1:0] elemIdx
);
  localparam int CNT_W = $clog2(MAX_LEN + PIPE_D + 1) + 1;
  localparam logic [CNT_W-1:0] DRAIN = CNT_W'(PIPE_D - 1);

  logic [CNT_W-1:0] cnt;
  logic             isVec;
  logic [CNT_W-1:0] lastCnt;

  assign isVec       = (issueOp <= OP_CMPEQ);
  assign issueAccept = issueValid && !busy;
  assign lastCnt     = CNT_W'(vlCur) + DRAIN;

  always_comb begin
    ctl           = '0;
    ctl.start     = issueAccept && isVec;
    ctl.loadVl    = issueAccept && (issueOp == OP_SETVL);
    ctl.loadMask  = issueAccept && (issueOp == OP_SETMASK);
    ctl.elemIssue = busy && (cnt < CNT_W'(vlCur));
  end

  assign elemIdx = cnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (ctl.start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == lastCnt) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.start && !ctl.loadVl && !ctl.loadMask);
endmodule

// File: rtl/vmu_dpath.sv
module vmu_dpath
  import vmu_pkg::*;
#(
  parameter int ELEM_W   = 16,
  parameter int MAX_LEN  = 64,
  parameter int NUM_REGS = 4,
  parameter int PIPE_D   = 3,
  parameter int SCALAR_W = 64,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  vctl_t               ctl,
  input  logic [IDX_W-1:0]    elemIdx,
  input  logic                busy,
  input  vop_e                issueOp,
  input  logic [REG_W-1:0]    issueDst,
  input  logic [REG_W-1:0]    issueSrcA,
  input  logic [REG_W-1:0]    issueSrcB,
  input  logic [SCALAR_W-1:0] issueScalar,
  input  logic                hostWrEn,
  input  logic [REG_W-1:0]    hostWrReg,
  input  logic [IDX_W-1:0]    hostWrIdx,
  input  logic [ELEM_W-1:0]   hostWrData,
  input  logic [REG_W-1:0]    rdReg,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [ELEM_W-1:0]   rdData,
  output logic [LEN_W-1:0]    vlOut,
  output logic [MAX_LEN-1:0]  maskOut
);
  typedef struct packed {
    logic              v;
    logic              we;
    logic              cmp;
    logic [IDX_W-1:0]  idx;
    logic [ELEM_W-1:0] res;
  } stage_t;

  logic [ELEM_W-1:0]  regFile [NUM_REGS][MAX_LEN];
  logic [MAX_LEN-1:0] maskReg;
  logic [LEN_W-1:0]   vlReg;

  vop_e              opQ;
  logic [REG_W-1:0]  dstQ, srcAQ, srcBQ;
  logic [ELEM_W-1:0] scalQ;

  logic [ELEM_W-1:0] opA, opB, result;
  logic              isScalar;
  stage_t            inStage, wb;

  // latch the accepted vector instruction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= OP_NOP;
      dstQ  <= '0;
      srcAQ <= '0;
      srcBQ <= '0;
      scalQ <= '0;
    end else if (ctl.start) begin
      opQ   <= issueOp;
      dstQ  <= issueDst;
      srcAQ <= issueSrcA;
      srcBQ <= issueSrcB;
      scalQ <= issueScalar[ELEM_W-1:0];
    end
  end

  // operand fetch and element compute
  assign isScalar = (opQ == OP_ADDSV) || (opQ == OP_MULSV);
  assign opA      = isScalar ? scalQ : regFile[srcAQ][elemIdx];
  assign opB      = regFile[srcBQ][elemIdx];

  always_comb begin
    unique case (opQ)
      OP_ADDVV, OP_ADDSV: result = opA + opB;
      OP_MULVV, OP_MULSV: result = ELEM_W'(opA * opB);
      OP_CMPEQ:           result = {{(ELEM_W-1){1'b0}}, (opA == opB)};
      default:            result = '0;
    endcase
  end

  always_comb begin
    inStage     = '0;
    inStage.v   = ctl.elemIssue;
    inStage.cmp = (opQ == OP_CMPEQ);
    inStage.we  = (opQ == OP_CMPEQ) || maskReg[elemIdx];
    inStage.idx = elemIdx;
    inStage.res = result;
  end

  // fixed-depth element pipeline
  for (genvar s = 0; s < PIPE_D; s++) begin : g_stage
    stage_t q;
    stage_t d;
    if (s == 0) begin : g_first
      assign d = inStage;
    end else begin : g_next
      assign d = g_stage[s-1].q;
    end
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else       q <= d;
    end
  end

  assign wb = g_stage[PIPE_D-1].q;

  // vector register write-back and host load
  always_ff @(posedge clk) begin
    if (wb.v && wb.we && !wb.cmp) regFile[dstQ][wb.idx] <= wb.res;
    if (hostWrEn) regFile[hostWrReg][hostWrIdx] <= hostWrData;
  end

  // control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlReg   <= LEN_W'(MAX_LEN);
      maskReg <= '1;
    end else begin
      if (ctl.loadVl) begin
        if (issueScalar > SCALAR_W'(MAX_LEN)) vlReg <= LEN_W'(MAX_LEN);
        else                                  vlReg <= issueScalar[LEN_W-1:0];
      end
      if (ctl.loadMask) maskReg <= issueScalar[MAX_LEN-1:0];
      else if (wb.v && wb.cmp) maskReg[wb.idx] <= wb.res[0];
    end
  end

  assign rdData  = regFile[rdReg][rdIdx];
  assign vlOut   = vlReg;
  assign maskOut = maskReg;

  // R6
  wb_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wb.v |-> (LEN_W'(wb.idx) < vlReg));
  // R7
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    vlReg <= LEN_W'(MAX_LEN));
  // R9
  vl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(vlReg));
  // R4
  cmp_mask_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(wb.v && wb.cmp)) |=> $stable(maskReg));
endmodule

// File: rtl/vec_mask_exec.sv
module vec_mask_exec
  import vmu_pkg::*;
#(
  parameter int ELEM_W   = 16,
  parameter int MAX_LEN  = 64,
  parameter int NUM_REGS = 4,
  parameter int PIPE_D   = 3,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int SCALAR_W = (MAX_LEN > ELEM_W) ? MAX_LEN : ELEM_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [2:0]          issueOp,
  input  logic [REG_W-1:0]    issueDst,
  input  logic [REG_W-1:0]    issueSrcA,
  input  logic [REG_W-1:0]    issueSrcB,
  input  logic [SCALAR_W-1:0] issueScalar,
  output logic                issueAccept,
  output logic                busy,
  output logic                done,
  input  logic                hostWrEn,
  input  logic [REG_W-1:0]    hostWrReg,
  input  logic [IDX_W-1:0]    hostWrIdx,
  input  logic [ELEM_W-1:0]   hostWrData,
  input  logic [REG_W-1:0]    rdReg,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [ELEM_W-1:0]   rdData,
  output logic [LEN_W-1:0]    vlOut,
  output logic [MAX_LEN-1:0]  maskOut
);
  vctl_t            ctl;
  logic [IDX_W-1:0] elemIdx;
  vop_e             opIn;

  assign opIn = vop_e'(issueOp);

  vmu_ctrl #(.MAX_LEN(MAX_LEN), .PIPE_D(PIPE_D)) ctrl_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(opIn),
    .vlCur(vlOut), .issueAccept(issueAccept), .busy(busy), .done(done),
    .ctl(ctl), .elemIdx(elemIdx)
  );

  vmu_dpath #(.ELEM_W(ELEM_W), .MAX_LEN(MAX_LEN), .NUM_REGS(NUM_REGS),
              .PIPE_D(PIPE_D), .SCALAR_W(SCALAR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .elemIdx(elemIdx), .busy(busy),
    .issueOp(opIn), .issueDst(issueDst), .issueSrcA(issueSrcA),
    .issueSrcB(issueSrcB), .issueScalar(issueScalar),
    .hostWrEn(hostWrEn), .hostWrReg(hostWrReg), .hostWrIdx(hostWrIdx),
    .hostWrData(hostWrData), .rdReg(rdReg), .rdIdx(rdIdx), .rdData(rdData),
    .vlOut(vlOut), .maskOut(maskOut)
  );
endmodule

// File: tb/vec_mask_exec_tb.sv
module vec_mask_exec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 16;
  localparam int ML = 64;
  localparam int NR = 4;
  localparam int PD = 3;
  localparam int NT = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [2:0] issueOp = '0;
  logic [1:0] issueDst = '0, issueSrcA = '0, issueSrcB = '0;
  logic [63:0] issueScalar = '0;
  logic issueAccept, busy, done;
  logic hostWrEn = 1'b0;
  logic [1:0] hostWrReg = '0;
  logic [5:0] hostWrIdx = '0;
  logic [EW-1:0] hostWrData = '0;
  logic [1:0] rdReg = '0;
  logic [5:0] rdIdx = '0;
  logic [EW-1:0] rdData;
  logic [6:0] vlOut;
  logic [ML-1:0] maskOut;

  int checks = 0, errors = 0, cycles = 0;
  logic [EW-1:0] mReg [NR][ML];
  logic [ML-1:0] mMask;
  int mVl;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_mask_exec #(.ELEM_W(EW), .MAX_LEN(ML), .NUM_REGS(NR), .PIPE_D(PD)) dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueScalar(issueScalar), .issueAccept(issueAccept), .busy(busy),
    .done(done), .hostWrEn(hostWrEn), .hostWrReg(hostWrReg),
    .hostWrIdx(hostWrIdx), .hostWrData(hostWrData), .rdReg(rdReg),
    .rdIdx(rdIdx), .rdData(rdData), .vlOut(vlOut), .maskOut(maskOut)
  );

  // table entry: {op[2:0], dst[1:0], srcA[1:0], srcB[1:0], scalar[15:0], length[6:0]}
  localparam logic [31:0] TBL [NT] = '{
    {3'd0, 2'd2, 2'd0, 2'd1, 16'd0,      7'd64},
    {3'd4, 2'd0, 2'd0, 2'd1, 16'd0,      7'd64},
    {3'd3, 2'd3, 2'd0, 2'd1, 16'd9,      7'd64},
    {3'd1, 2'd2, 2'd0, 2'd2, 16'hFFF0,   7'd40},
    {3'd4, 2'd0, 2'd2, 2'd2, 16'd0,      7'd10},
    {3'd2, 2'd1, 2'd0, 2'd1, 16'd0,      7'd12},
    {3'd0, 2'd0, 2'd0, 2'd0, 16'd0,      7'd64},
    {3'd4, 2'd0, 2'd3, 2'd0, 16'd0,      7'd64}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // independent model of one vector instruction
  task automatic modelVec(input int op, input int d, input int a, input int b, input logic [EW-1:0] s);
    for (int i = 0; i < mVl; i++) begin
      logic [EW-1:0] x, y;
      x = (op == 1 || op == 3) ? s : mReg[a][i];
      y = mReg[b][i];
      if (op == 4) mMask[i] = (x == y);
      else if (mMask[i]) mReg[d][i] = (op < 2) ? EW'(x + y) : EW'(x * y);
    end
  endtask

  task automatic issueSet(input int op, input logic [63:0] s);
    @(negedge clk);
    issueValid = 1'b1; issueOp = 3'(op); issueScalar = s;
    @(negedge clk);
    issueValid = 1'b0;
    if (op == 5) mVl = (s > 64'(ML)) ? ML : int'(s);
    if (op == 6) mMask = s;
  endtask

  // issue a vector instruction, return cycles from acceptance to done
  task automatic runVec(input int op, input int d, input int a, input int b,
                        input logic [EW-1:0] s, output int lat);
    @(negedge clk);
    issueValid = 1'b1; issueOp = 3'(op); issueDst = 2'(d);
    issueSrcA = 2'(a); issueSrcB = 2'(b); issueScalar = 64'(s);
    @(negedge clk);
    issueValid = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    modelVec(op, d, a, b, s);
  endtask

  task automatic compareAll(input string req);
    int bad = 0;
    logic [EW-1:0] fa = '0, fe = '0;
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < ML; i++) begin
        rdReg = 2'(r); rdIdx = 6'(i);
        #1;
        if (rdData !== mReg[r][i]) begin
          if (bad == 0) begin fa = rdData; fe = mReg[r][i]; end
          bad++;
        end
      end
    check({req, " regs"}, 64'(fa), 64'(fe));
    check({req, " mask"}, maskOut, mMask);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 0);
    check("R1 done", 64'(done), 0);
    check("R1 length", 64'(vlOut), 64'(ML));
    check("R1 mask", maskOut, '1);
    mVl = ML; mMask = '1;

    // host load of register contents
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < ML; i++) begin
        logic [EW-1:0] v;
        case (r)
          0: v = EW'(i * 7 + 3 + 16'h4000);
          1: v = (i % 3 == 0) ? EW'(i * 7 + 3 + 16'h4000) : EW'((i * 7 + 3 + 16'h4000) ^ 16'h0100);
          2: v = EW'(i * 1000);
          default: v = EW'(16'hBEEF ^ i);
        endcase
        mReg[r][i] = v;
        @(negedge clk);
        hostWrEn = 1'b1; hostWrReg = 2'(r); hostWrIdx = 6'(i); hostWrData = v;
      end
    @(negedge clk);
    hostWrEn = 1'b0;

    // table walk: R2 R3 R4 R5 R6 R8
    for (int t = 0; t < NT; t++) begin
      logic [31:0] e;
      e = TBL[t];
      issueSet(5, 64'(e[6:0]));
      runVec(int'(e[31:29]), int'(e[28:27]), int'(e[26:25]), int'(e[24:23]), e[22:7], lat);
      check("R8 latency", 64'(lat), 64'(mVl + PD + 1));
      compareAll(reqOf(int'(e[31:29])));
    end

    // R5 masked add with a loaded mask pattern
    issueSet(5, 64);
    issueSet(6, 64'hF0F0_0FF0_1234_8001);
    check("R7 mask load", maskOut, 64'hF0F0_0FF0_1234_8001);
    runVec(1, 2, 0, 2, 16'd1, lat);
    compareAll("R5");

    // R5 R8 all-zero mask: full time, nothing written
    issueSet(6, 64'd0);
    issueSet(5, 20);
    runVec(0, 3, 0, 1, 16'd0, lat);
    check("R8 zero-mask latency", 64'(lat), 64'(20 + PD + 1));
    compareAll("R5 zero mask");

    // R7 length clamp
    issueSet(5, 100);
    check("R7 clamp", 64'(vlOut), 64'(ML));

    // R10 length zero
    issueSet(6, '1);
    issueSet(5, 0);
    runVec(0, 2, 0, 1, 16'd0, lat);
    check("R10 latency", 64'(lat), 64'(PD + 1));
    compareAll("R10");

    // R9 refusal while busy
    issueSet(5, 64);
    @(negedge clk);
    issueValid = 1'b1; issueOp = 3'd0; issueDst = 2'd2; issueSrcA = 2'd0; issueSrcB = 2'd1;
    @(negedge clk);
    issueOp = 3'd5; issueScalar = 64'd5;
    #1;
    check("R9 accept low", 64'(issueAccept), 0);
    @(negedge clk);
    issueOp = 3'd6; issueScalar = 64'd0;
    @(negedge clk);
    issueOp = 3'd3; issueDst = 2'd1; issueScalar = 64'd3;
    @(negedge clk);
    issueValid = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    modelVec(0, 2, 0, 1, '0);
    check("R9 length kept", 64'(vlOut), 64'(ML));
    compareAll("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule